// File: doc/BRIEF.md
# Program Sequencer with Single-Level Call Stack

This block produces the instruction address for a small 4-bit controller. It holds an 11-bit program counter. The counter changes on every valid instruction. A sequential instruction moves it forward by its byte length. A jump loads the target address. A call saves the current counter into a one-entry return-address register before it loads the target. A return copies the saved address back into the counter.

A one-bit depth flag tracks whether the return register holds a live entry. A call when the entry is already in use is an overflow. A return when it is empty is an underflow. Either one raises a one-cycle self-reset pulse, and the counter and flag clear on the following edge. The stack is never allowed to wrap.

The low byte of the return register doubles as a data-memory location, with a byte port for reading and writing it. Any access through that port replaces the top three bits of the register with a fixed filler value.

Top module: `prog_seq`

## Requirements
- R1: While `rst_n` is low, `pc` is 0x000, `sp` is 0 and `fault_rst` is 0.
- R2: A valid instruction of kind 2'b00 (sequential) sets `pc` to `pc + instr_len`, modulo 2^11, at the next edge.
- R3: A valid instruction of kind 2'b01 (jump) sets `pc` to `instr_target` at the next edge.
- R4: A valid instruction of kind 2'b10 (call) with `sp` = 0 stores the current `pc` in the return register, sets `pc` to `instr_target` and sets `sp` to 1, all at the next edge.
- R5: A valid instruction of kind 2'b11 (return) with `sp` = 1 sets `pc` to the stored address and clears `sp`. The return register keeps its value.
- R6: A call with `sp` = 1 raises `fault_rst` for exactly one cycle at the next edge and leaves `pc`, `sp` and the return register unchanged at that edge. On the edge after that, `pc` becomes 0x000 and `sp` becomes 0.
- R7: A return with `sp` = 0 raises `fault_rst` in the same way as R6, with the same clearing of `pc` and `sp` one edge later.
- R8: Any instruction presented in the cycle where `fault_rst` is high is ignored.
- R9: `dm_rdata` always shows bits [7:0] of the return register, with no delay. An edge where `dm_sel` is 1 and no call is stored sets bits [10:8] to the filler value (default 3'b111).
- R10: An edge where `dm_sel` and `dm_we` are both 1 writes `dm_wdata` into bits [7:0] of the return register.
- R11: When a call is stored in the same cycle as a data-port access, the call's save wins and the data-port access has no effect.
- R12: When `instr_valid` is 0, `pc` and `sp` hold their values.
- R13: Reset does not change the return register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | An instruction executes this cycle |
| instr_kind | input | 2 | 00 sequential, 01 jump, 10 call, 11 return |
| instr_len | input | 2 | Byte length of a sequential instruction |
| instr_target | input | 11 | Jump or call target address |
| dm_sel | input | 1 | Data-port access to the return-register low byte |
| dm_we | input | 1 | Write strobe for the data port |
| dm_wdata | input | 8 | Data-port write byte |
| dm_rdata | output | 8 | Low byte of the return register |
| pc | output | 11 | Program counter |
| sp | output | 1 | Stack depth flag |
| fault_rst | output | 1 | One-cycle self-reset request on stack fault |

## Verification
The vector walk runs the sequencer through runs of sequential steps with lengths 1, 2 and 3, so an adder that ignores the length or one of its bits shows up. Steps that cross 0x7FF catch a missing wrap. A call and return pair with a sequential step in between shows whether the return uses the saved address rather than the target or the current counter. A call made on top of a live entry and a return made with nothing saved each produce a fault, and the instruction presented during the pulse must not move the counter. Directed cases reach the data port through the return path. A return after a write, and another after a read-only access, expose the filler bits, and a call together with a port write shows which of the two wins.

// File: rtl/prog_seq_pkg.sv
package prog_seq_pkg;

    typedef enum logic [1:0] {
        K_SEQ  = 2'b00,
        K_JUMP = 2'b01,
        K_CALL = 2'b10,
        K_RET  = 2'b11
    } instr_kind_e;

endpackage

// File: rtl/prog_seq_adder.sv
module prog_seq_adder #(
    parameter int ADDR_W = 11,
    parameter int LEN_W  = 2
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [LEN_W-1:0]  step,
    output logic [ADDR_W-1:0] sum
);
    localparam int PAD_W = ADDR_W - LEN_W;

    // modulo-2^ADDR_W increment: the carry out of the top bit is dropped
    always_comb begin
        sum = base + {{PAD_W{1'b0}}, step};
    end
endmodule

// File: rtl/prog_seq_guard.sv
module prog_seq_guard (
    input  logic       instr_valid,
    input  logic [1:0] instr_kind,
    input  logic       sp,
    input  logic       busy,
    output logic       overflow,
    output logic       underflow
);
    import prog_seq_pkg::*;

    logic live;

    always_comb begin
        live      = instr_valid && !busy;
        overflow  = live && (instr_kind == K_CALL) && sp;
        underflow = live && (instr_kind == K_RET) && !sp;
    end
endmodule

// File: rtl/prog_seq_stack.sv
module prog_seq_stack #(
    parameter int                          ADDR_W = 11,
    parameter int                          DM_W   = 8,
    parameter logic [ADDR_W-DM_W-1:0]      FILL   = '1
) (
    input  logic              clk,
    input  logic              save_en,
    input  logic [ADDR_W-1:0] save_val,
    input  logic              dm_sel,
    input  logic              dm_we,
    input  logic [DM_W-1:0]   dm_wdata,
    output logic [ADDR_W-1:0] ret_addr,
    output logic [DM_W-1:0]   dm_rdata
);
    localparam int HI_W = ADDR_W - DM_W;

    typedef struct packed {
        logic [HI_W-1:0] hi;
        logic [DM_W-1:0] lo;
    } ret_t;

    ret_t ret_d, ret_q;

    always_comb begin
        ret_d = ret_q;
        if (save_en) begin
            ret_d = ret_t'(save_val);
        end else if (dm_sel) begin
            ret_d.hi = FILL;
            if (dm_we) begin
                ret_d.lo = dm_wdata;
            end
        end
    end

    // no reset: the return register keeps its value across resets
    always_ff @(posedge clk) begin
        ret_q <= ret_d;
    end

    assign ret_addr = ret_q;
    assign dm_rdata = ret_q.lo;
endmodule

// File: rtl/prog_seq.sv
module prog_seq #(
    parameter int                     ADDR_W = 11,
    parameter int                     LEN_W  = 2,
    parameter int                     DM_W   = 8,
    parameter logic [ADDR_W-DM_W-1:0] FILL   = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic [1:0]        instr_kind,
    input  logic [LEN_W-1:0]  instr_len,
    input  logic [ADDR_W-1:0] instr_target,
    input  logic              dm_sel,
    input  logic              dm_we,
    input  logic [DM_W-1:0]   dm_wdata,
    output logic [DM_W-1:0]   dm_rdata,
    output logic [ADDR_W-1:0] pc,
    output logic              sp,
    output logic              fault_rst
);
    import prog_seq_pkg::*;

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
        logic              sp;
        logic              fault;
    } seq_t;

    seq_t              st_d, st_q;
    logic [ADDR_W-1:0] pc_inc;
    logic [ADDR_W-1:0] ret_addr;
    logic              ovf, udf;
    logic              save_en;

    prog_seq_adder #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_add (
        .base (st_q.pc),
        .step (instr_len),
        .sum  (pc_inc)
    );

    prog_seq_guard u_guard (
        .instr_valid (instr_valid),
        .instr_kind  (instr_kind),
        .sp          (st_q.sp),
        .busy        (st_q.fault),
        .overflow    (ovf),
        .underflow   (udf)
    );

    prog_seq_stack #(.ADDR_W(ADDR_W), .DM_W(DM_W), .FILL(FILL)) u_stk (
        .clk      (clk),
        .save_en  (save_en),
        .save_val (st_q.pc),
        .dm_sel   (dm_sel),
        .dm_we    (dm_we),
        .dm_wdata (dm_wdata),
        .ret_addr (ret_addr),
        .dm_rdata (dm_rdata)
    );

    always_comb begin
        st_d    = st_q;
        save_en = 1'b0;
        if (st_q.fault) begin
            st_d.pc    = '0;
            st_d.sp    = 1'b0;
            st_d.fault = 1'b0;
        end else if (ovf || udf) begin
            st_d.fault = 1'b1;
        end else if (instr_valid) begin
            case (instr_kind_e'(instr_kind))
                K_SEQ:  st_d.pc = pc_inc;
                K_JUMP: st_d.pc = instr_target;
                K_CALL: begin
                    save_en  = 1'b1;
                    st_d.pc  = instr_target;
                    st_d.sp  = 1'b1;
                end
                default: begin
                    st_d.pc = ret_addr;
                    st_d.sp = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pc        = st_q.pc;
    assign sp        = st_q.sp;
    assign fault_rst = st_q.fault;
endmodule

// File: rtl/prog_seq_chk.sv
module prog_seq_chk #(
    parameter int ADDR_W = 11,
    parameter int LEN_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              instr_valid,
    input logic [1:0]        instr_kind,
    input logic [LEN_W-1:0]  instr_len,
    input logic [ADDR_W-1:0] instr_target,
    input logic [ADDR_W-1:0] pc,
    input logic              sp,
    input logic              fault_rst
);
    localparam int PAD_W = ADDR_W - LEN_W;

    AST_RESET_STATE: assert property (@(posedge clk) !rst_n |-> (pc == '0 && !sp && !fault_rst)); // R1

    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && !fault_rst && instr_kind == 2'b00)
        |=> pc == ADDR_W'($past(pc) + {{PAD_W{1'b0}}, $past(instr_len)})); // R2

    AST_JUMP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && !fault_rst && instr_kind == 2'b01) |=> pc == $past(instr_target)); // R3

    AST_CALL_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && !fault_rst && instr_kind == 2'b10 && !sp)
        |=> (sp && pc == $past(instr_target))); // R4

    AST_RET_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && !fault_rst && instr_kind == 2'b11 && sp) |=> (!sp && !fault_rst)); // R5

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && !fault_rst && instr_kind == 2'b10 && sp)
        |=> (fault_rst && sp && $stable(pc))); // R6

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && !fault_rst && instr_kind == 2'b11 && !sp)
        |=> (fault_rst && !sp && $stable(pc))); // R7

    AST_FAULT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        fault_rst |=> (!fault_rst && pc == '0 && !sp)); // R8

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!instr_valid && !fault_rst) |=> ($stable(pc) && $stable(sp) && !fault_rst)); // R12
endmodule

bind prog_seq prog_seq_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .instr_valid  (instr_valid),
    .instr_kind   (instr_kind),
    .instr_len    (instr_len),
    .instr_target (instr_target),
    .pc           (pc),
    .sp           (sp),
    .fault_rst    (fault_rst)
);

// File: tb/prog_seq_bench.sv
module prog_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [1:0]  instr_kind = 2'b00;
    logic [1:0]  instr_len = 2'd0;
    logic [10:0] instr_target = '0;
    logic        dm_sel = 1'b0;
    logic        dm_we = 1'b0;
    logic [7:0]  dm_wdata = '0;
    logic [7:0]  dm_rdata;
    logic [10:0] pc;
    logic        sp;
    logic        fault_rst;

    int total = 0;
    int bad = 0;

    always #5ns clk = ~clk;

    prog_seq u_prog_seq (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_kind(instr_kind),
        .instr_len(instr_len), .instr_target(instr_target), .dm_sel(dm_sel), .dm_we(dm_we),
        .dm_wdata(dm_wdata), .dm_rdata(dm_rdata), .pc(pc), .sp(sp), .fault_rst(fault_rst)
    );

    // kind, len, target, expected pc, expected sp, expected fault
    localparam int NV = 16;
    localparam logic [27:0] VEC [NV] = '{
        {2'd0, 2'd1, 11'h000, 11'h001, 1'b0, 1'b0},
        {2'd0, 2'd2, 11'h000, 11'h003, 1'b0, 1'b0},
        {2'd0, 2'd3, 11'h000, 11'h006, 1'b0, 1'b0},
        {2'd1, 2'd0, 11'h7FE, 11'h7FE, 1'b0, 1'b0},
        {2'd0, 2'd3, 11'h000, 11'h001, 1'b0, 1'b0},
        {2'd2, 2'd0, 11'h123, 11'h123, 1'b1, 1'b0},
        {2'd0, 2'd1, 11'h000, 11'h124, 1'b1, 1'b0},
        {2'd3, 2'd0, 11'h000, 11'h001, 1'b0, 1'b0},
        {2'd1, 2'd0, 11'h456, 11'h456, 1'b0, 1'b0},
        {2'd2, 2'd0, 11'h200, 11'h200, 1'b1, 1'b0},
        {2'd2, 2'd0, 11'h300, 11'h200, 1'b1, 1'b1},
        {2'd0, 2'd1, 11'h000, 11'h000, 1'b0, 1'b0},
        {2'd3, 2'd0, 11'h000, 11'h000, 1'b0, 1'b1},
        {2'd1, 2'd0, 11'h555, 11'h000, 1'b0, 1'b0},
        {2'd1, 2'd0, 11'h7FF, 11'h7FF, 1'b0, 1'b0},
        {2'd0, 2'd1, 11'h000, 11'h000, 1'b0, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // present inputs, let one rising edge pass, then return to idle
    task automatic step(input logic v, input logic [1:0] k, input logic [1:0] l,
                        input logic [10:0] t, input logic s, input logic w, input logic [7:0] d);
        instr_valid = v; instr_kind = k; instr_len = l; instr_target = t;
        dm_sel = s; dm_we = w; dm_wdata = d;
        @(posedge clk);
        #2ns;
        instr_valid = 1'b0; dm_sel = 1'b0; dm_we = 1'b0;
    endtask

    initial begin
        #2ms;
        bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2ns;
        check("R1 pc in reset", 32'(pc), 32'h0);
        check("R1 sp in reset", 32'(sp), 32'h0);
        check("R1 fault in reset", 32'(fault_rst), 32'h0);
        rst_n = 1'b1;
        @(posedge clk);
        #2ns;

        // R2 R3 R4 R5 R6 R7 R8: table walk
        for (int i = 0; i < NV; i++) begin
            step(1'b1, VEC[i][27:26], VEC[i][25:24], VEC[i][23:13], 1'b0, 1'b0, 8'h00);
            check($sformatf("R2-step%0d pc (R3 R4 R5 R8)", i), 32'(pc), 32'(VEC[i][12:2]));
            check($sformatf("R6 R7 step%0d sp", i), 32'(sp), 32'(VEC[i][1]));
            check($sformatf("R6 R7 step%0d fault", i), 32'(fault_rst), 32'(VEC[i][0]));
            if (i == 9) check("R4 saved low byte", 32'(dm_rdata), 32'h56);
        end
        // R6: faults leave the return register alone
        check("R6 return reg kept", 32'(dm_rdata), 32'h56);

        // R13: reset keeps the return register
        rst_n = 1'b0;
        #3ns;
        check("R1 pc async reset", 32'(pc), 32'h0);
        @(posedge clk);
        #2ns;
        rst_n = 1'b1;
        check("R13 return reg across reset", 32'(dm_rdata), 32'h56);
        @(posedge clk);
        #2ns;

        // R5: return register kept after return
        step(1'b1, 2'd1, 2'd0, 11'h1AB, 1'b0, 1'b0, 8'h00);
        step(1'b1, 2'd2, 2'd0, 11'h010, 1'b0, 1'b0, 8'h00);
        step(1'b1, 2'd3, 2'd0, 11'h000, 1'b0, 1'b0, 8'h00);
        check("R5 return pc", 32'(pc), 32'h1AB);
        check("R5 return reg kept", 32'(dm_rdata), 32'hAB);

        // R10 R9: write through the data port, then return
        step(1'b1, 2'd2, 2'd0, 11'h020, 1'b0, 1'b0, 8'h00);
        step(1'b0, 2'd0, 2'd0, 11'h000, 1'b1, 1'b1, 8'hA5);
        check("R10 written byte", 32'(dm_rdata), 32'hA5);
        step(1'b1, 2'd3, 2'd0, 11'h000, 1'b0, 1'b0, 8'h00);
        check("R10 R9 return after write", 32'(pc), 32'h7A5);

        // R9: a read-only access also fills the top bits
        step(1'b1, 2'd1, 2'd0, 11'h0C3, 1'b0, 1'b0, 8'h00);
        step(1'b1, 2'd2, 2'd0, 11'h010, 1'b0, 1'b0, 8'h00);
        dm_sel = 1'b1;
        #1ns;
        check("R9 immediate read", 32'(dm_rdata), 32'hC3);
        step(1'b0, 2'd0, 2'd0, 11'h000, 1'b1, 1'b0, 8'h00);
        step(1'b1, 2'd3, 2'd0, 11'h000, 1'b0, 1'b0, 8'h00);
        check("R9 return after read", 32'(pc), 32'h7C3);

        // R11: a call beats a port write in the same cycle
        step(1'b1, 2'd1, 2'd0, 11'h234, 1'b0, 1'b0, 8'h00);
        step(1'b1, 2'd2, 2'd0, 11'h010, 1'b1, 1'b1, 8'hFF);
        check("R11 saved byte", 32'(dm_rdata), 32'h34);
        step(1'b1, 2'd3, 2'd0, 11'h000, 1'b0, 1'b0, 8'h00);
        check("R11 return pc", 32'(pc), 32'h234);

        // R12: invalid instructions hold pc and sp
        step(1'b0, 2'd1, 2'd0, 11'h3CC, 1'b0, 1'b0, 8'h00);
        check("R12 pc held", 32'(pc), 32'h234);
        step(1'b0, 2'd2, 2'd0, 11'h3CC, 1'b0, 1'b0, 8'h00);
        check("R12 sp held", 32'(sp), 32'h0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule